// File: doc/BRIEF.md
# Single-channel DMA element mover

This block is one channel of a DMA engine. It copies data elements, one byte or one 16-bit word at a time, between a single peripheral data register and a buffer held in a dedicated dual-port RAM. The channel has its own RAM port and its own peripheral register port, so a processor never waits on it. Software programs a set of configuration inputs: transfer direction, element size, RAM addressing style, sequencing mode, request source, block length and two buffer start addresses. It then raises the channel enable.

Each rising edge on the selected peripheral request line moves exactly one element. A rising edge on the software force input does the same. The channel keeps a RAM address and counts elements within a block. At the end of a block it stops, restarts the same buffer, or switches to the other buffer, according to the mode. An interrupt pulse marks either the end of a block or the point where half of the block has been moved.

Top module: `dma_xfer_chan`

## Requirements
- R1: After reset, `irq`, `armed`, `pp_last_alt`, `ram_we`, `ram_re`, `periph_re` and `periph_we` are all 0.
- R2: With `cfg_dir`=0 (peripheral to RAM), a transfer cycle asserts `periph_re` and `ram_we` together. In that cycle `ram_wdata` carries the peripheral data.
- R3: With `cfg_dir`=1 (RAM to peripheral), a transfer cycle asserts `ram_re` and `periph_we` together. In that cycle `periph_wdata` carries the RAM data.
- R4: With `cfg_byte`=1 the element is one byte. `ram_be` is 2'b01 for an even address and 2'b10 for an odd one. The byte is copied onto both halves of `ram_wdata`. On a read, the addressed RAM byte appears in `periph_wdata[7:0]` with the upper byte 0. With post-increment, the address advances by 1.
- R5: With `cfg_byte`=0 the element is a word. `ram_be` is 2'b11 and `ram_addr[0]` is always 0. With post-increment, the address advances by 2.
- R6: With `cfg_incr`=0 every element of a block uses the block's start address.
- R7: A transfer cycle follows, one clock later, each rising edge of `req_vec[cfg_src_sel]`. Other request lines have no effect. A select value of 19 or more never triggers.
- R8: A rising edge of `sw_force` moves one element, exactly as a request edge does.
- R9: A block is `cfg_count`+1 elements. In mode 0 (one-shot), `irq` pulses for one cycle after the last element and `armed` falls at the same time. Later requests move nothing.
- R10: In mode 1 (continuous), the address returns to `cfg_start_a` after each block and `armed` stays 1.
- R11: In mode 2 (ping-pong), blocks alternate between `cfg_start_a` and `cfg_start_b`, starting with `cfg_start_a`. `pp_last_alt` is 0 after a primary block and 1 after a secondary one. Mode 3 behaves the same but disarms after the secondary block.
- R12: With `cfg_half`=1, `irq` pulses once per block, after floor((`cfg_count`+1)/2) elements, and not at block end. When that count is 0, no interrupt is raised.
- R13: Lowering `cfg_en` aborts the block: `armed` goes to 0 with no `irq`. A later enable restarts at `cfg_start_a` with a fresh element count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Channel enable; a rising edge arms the channel |
| cfg_dir | input | 1 | 0 peripheral to RAM, 1 RAM to peripheral |
| cfg_byte | input | 1 | 1 byte elements, 0 word elements |
| cfg_incr | input | 1 | 1 post-increment RAM address, 0 fixed |
| cfg_mode | input | 2 | 0 one-shot, 1 continuous, 2 ping-pong, 3 ping-pong one pass |
| cfg_half | input | 1 | 1 interrupt at half block instead of block end |
| cfg_src_sel | input | SRC_W (5) | Index of the request line that triggers transfers |
| cfg_count | input | CNT_W (10) | Block length minus one |
| cfg_start_a | input | ADDR_W (12) | Primary buffer start byte address |
| cfg_start_b | input | ADDR_W (12) | Secondary buffer start byte address |
| req_vec | input | NUM_SRC (19) | Peripheral request lines |
| sw_force | input | 1 | Software force; a rising edge moves one element |
| ram_addr | output | ADDR_W (12) | RAM byte address |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_be | output | 2 | RAM byte lane enables |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, valid in the strobe cycle |
| periph_re | output | 1 | Peripheral register read strobe |
| periph_we | output | 1 | Peripheral register write strobe |
| periph_wdata | output | 16 | Peripheral register write data |
| periph_rdata | input | 16 | Peripheral register read data, valid in the strobe cycle |
| irq | output | 1 | One-cycle interrupt pulse |
| armed | output | 1 | Channel armed and accepting requests |
| pp_last_alt | output | 1 | Last completed ping-pong buffer was the secondary one |

## Verification
A wrong address register shows at `ram_addr` in the very next transfer cycle, one clock after the request edge. A miscounted element total shows as an `irq` pulse one element early or late, or as `armed` falling at the wrong element. A stale buffer-select bit shows at the first element of the following block, because the start address comes back wrong. It also shows in `pp_last_alt` in the cycle after that block completes. An abort that leaves state behind shows in the first block after re-enable, either as an offset address or as an early interrupt.

// File: rtl/dxc_pkg.sv
// Package: shared types for the DMA transfer channel.
// Assumes: the mode encoding below is the one software programs.
package dxc_pkg;

    typedef enum logic [1:0] {
        MD_SINGLE    = 2'd0,
        MD_LOOP      = 2'd1,
        MD_PINGPONG  = 2'd2,
        MD_PP_SINGLE = 2'd3
    } dxc_mode_e;

endpackage

// File: rtl/dxc_trigger.sv
// Module: dxc_trigger
// Picks one request line through a select index and produces a one-cycle
// pulse on each rising edge of that line or of the software force input.
// Assumes: select values at or above NUM_SRC address unconnected (zero) lines.
module dxc_trigger #(
    parameter int NUM_SRC = 19,
    parameter int SRC_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_W-1:0]   sel,
    input  logic [NUM_SRC-1:0] req_vec,
    input  logic               sw_force,
    output logic               trig
);
    localparam int PAD_N = 1 << SRC_W;

    logic [PAD_N-1:0] padded;
    logic             sel_req;
    logic             req_q;
    logic             frc_q;

    // Pad the request vector so that every select code maps to a line.
    generate
        for (genvar g = 0; g < PAD_N; g++) begin : g_pad
            if (g < NUM_SRC) begin : g_live
                assign padded[g] = req_vec[g];
            end else begin : g_dead
                assign padded[g] = 1'b0;
            end
        end
    endgenerate

    // Select the chosen request line.
    always_comb sel_req = padded[sel];

    // Remember the previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            frc_q <= 1'b0;
        end else begin
            req_q <= sel_req;
            frc_q <= sw_force;
        end
    end

    // Rising edge of either source is a trigger.
    always_comb trig = (sel_req & ~req_q) | (sw_force & ~frc_q);

endmodule

// File: rtl/dxc_block_ctr.sv
// Module: dxc_block_ctr
// Counts elements inside a block of last_n+1 elements and flags the element
// that completes the block and the element that reaches the half point.
// Assumes: last_n is stable while a block is in progress.
module dxc_block_ctr #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] last_n,
    output logic             done,
    output logic             half_hit
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   half_len;
    logic [CNT_W:0]   next_cnt;

    // Half length is floor((last_n+1)/2); next_cnt is the count after this step.
    always_comb begin
        half_len = ({1'b0, last_n} + {{CNT_W{1'b0}}, 1'b1}) >> 1;
        next_cnt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    end

    // Flag the completing element and the half-point element.
    always_comb begin
        done     = step && (cnt == last_n);
        half_hit = step && (half_len != '0) && (next_cnt == half_len);
    end

    // Element counter, cleared at block end or on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= done ? '0 : next_cnt[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/dxc_addr_gen.sv
// Module: dxc_addr_gen
// Holds the RAM byte address of the next element. It loads a start address,
// reloads one at block end, or post-increments by the element size.
// Assumes: ADDR_W is at least 3.
module dxc_addr_gen #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    input  logic              wrap,
    input  logic [ADDR_W-1:0] wrap_addr,
    input  logic              byte_sz,
    input  logic              post_inc,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              lane_hi
);
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] stride;

    // Stride is 1 for bytes and 2 for words.
    always_comb stride = {{(ADDR_W-2){1'b0}}, ~byte_sz, byte_sz};

    // Address register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_addr;
        end else if (step) begin
            if (wrap) begin
                addr <= wrap_addr;
            end else if (post_inc) begin
                addr <= addr + stride;
            end
        end
    end

    // Word accesses use an even address; byte accesses keep bit 0 as the lane.
    always_comb begin
        eff_addr = byte_sz ? addr : {addr[ADDR_W-1:1], 1'b0};
        lane_hi  = addr[0];
    end

endmodule

// File: rtl/dxc_lane_steer.sv
// Module: dxc_lane_steer
// Steers data between the 16-bit peripheral register and the RAM byte lanes
// for byte or word elements.
// Assumes: peripheral byte data sits in bits 7:0.
module dxc_lane_steer (
    input  logic        byte_sz,
    input  logic        lane_hi,
    input  logic [15:0] periph_rdata,
    input  logic [15:0] ram_rdata,
    output logic [1:0]  be,
    output logic [15:0] ram_wdata,
    output logic [15:0] periph_wdata
);
    // Lane enables and data placement by element size.
    always_comb begin
        if (byte_sz) begin
            be           = lane_hi ? 2'b10 : 2'b01;
            ram_wdata    = {periph_rdata[7:0], periph_rdata[7:0]};
            periph_wdata = {8'h00, lane_hi ? ram_rdata[15:8] : ram_rdata[7:0]};
        end else begin
            be           = 2'b11;
            ram_wdata    = periph_rdata;
            periph_wdata = ram_rdata;
        end
    end

endmodule

// File: rtl/dma_xfer_chan.sv
// Module: dma_xfer_chan (top)
// One DMA channel: moves one element per trigger between a peripheral
// register and a dual-port RAM, and sequences blocks in one-shot,
// continuous or ping-pong fashion with full- or half-block interrupts.
// Assumes: configuration inputs other than cfg_en change only while the
// channel is disabled; both data ports return read data in the strobe cycle.
module dma_xfer_chan #(
    parameter int NUM_SRC = 19,
    parameter int ADDR_W  = 12,
    parameter int CNT_W   = 10,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_dir,
    input  logic               cfg_byte,
    input  logic               cfg_incr,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_half,
    input  logic [SRC_W-1:0]   cfg_src_sel,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic [ADDR_W-1:0]  cfg_start_a,
    input  logic [ADDR_W-1:0]  cfg_start_b,
    input  logic [NUM_SRC-1:0] req_vec,
    input  logic               sw_force,
    output logic [ADDR_W-1:0]  ram_addr,
    output logic               ram_we,
    output logic               ram_re,
    output logic [1:0]         ram_be,
    output logic [15:0]        ram_wdata,
    input  logic [15:0]        ram_rdata,
    output logic               periph_re,
    output logic               periph_we,
    output logic [15:0]        periph_wdata,
    input  logic [15:0]        periph_rdata,
    output logic               irq,
    output logic               armed,
    output logic               pp_last_alt
);
    import dxc_pkg::*;

    dxc_mode_e         mode;
    logic              trig;
    logic              en_q;
    logic              en_rise;
    logic              pend;
    logic              xfer;
    logic              done;
    logic              half_hit;
    logic              is_pp;
    logic              stop_now;
    logic              buf_sec;
    logic              ctr_clear;
    logic              lane_hi;
    logic [1:0]        be_raw;
    logic [ADDR_W-1:0] wrap_addr;

    // Decode the mode field and the block-end policy.
    always_comb begin
        mode      = dxc_mode_e'(cfg_mode);
        is_pp     = (mode == MD_PINGPONG) || (mode == MD_PP_SINGLE);
        stop_now  = (mode == MD_SINGLE) || ((mode == MD_PP_SINGLE) && buf_sec);
        wrap_addr = (is_pp && !buf_sec) ? cfg_start_b : cfg_start_a;
        en_rise   = cfg_en & ~en_q;
        xfer      = pend & armed & cfg_en;
        ctr_clear = en_rise | ~cfg_en;
    end

    dxc_trigger #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (cfg_src_sel),
        .req_vec  (req_vec),
        .sw_force (sw_force),
        .trig     (trig)
    );

    dxc_block_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ctr_clear),
        .step     (xfer),
        .last_n   (cfg_count),
        .done     (done),
        .half_hit (half_hit)
    );

    dxc_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (en_rise),
        .load_addr (cfg_start_a),
        .step      (xfer),
        .wrap      (done),
        .wrap_addr (wrap_addr),
        .byte_sz   (cfg_byte),
        .post_inc  (cfg_incr),
        .eff_addr  (ram_addr),
        .lane_hi   (lane_hi)
    );

    dxc_lane_steer u_lane (
        .byte_sz      (cfg_byte),
        .lane_hi      (lane_hi),
        .periph_rdata (periph_rdata),
        .ram_rdata    (ram_rdata),
        .be           (be_raw),
        .ram_wdata    (ram_wdata),
        .periph_wdata (periph_wdata)
    );

    // Enable history, pending transfer and arm state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            pend  <= 1'b0;
            armed <= 1'b0;
        end else begin
            en_q <= cfg_en;
            pend <= cfg_en & armed & trig;
            if (!cfg_en) begin
                armed <= 1'b0;
            end else if (en_rise) begin
                armed <= 1'b1;
            end else if (xfer && done && stop_now) begin
                armed <= 1'b0;
            end
        end
    end

    // Ping-pong buffer tracking and completion status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_sec     <= 1'b0;
            pp_last_alt <= 1'b0;
        end else if (en_rise) begin
            buf_sec     <= 1'b0;
            pp_last_alt <= 1'b0;
        end else if (xfer && done && is_pp) begin
            buf_sec     <= ~buf_sec;
            pp_last_alt <= buf_sec;
        end
    end

    // Interrupt pulse at block end or at half point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= xfer & (cfg_half ? half_hit : done);
        end
    end

    // Port strobes for the active transfer cycle.
    always_comb begin
        ram_we    = xfer & ~cfg_dir;
        periph_re = xfer & ~cfg_dir;
        ram_re    = xfer & cfg_dir;
        periph_we = xfer & cfg_dir;
        ram_be    = xfer ? be_raw : 2'b00;
    end

endmodule

// File: rtl/dxc_checker.sv
// Module: dxc_checker
// Port-level properties of the DMA channel, attached to every instance of
// the top through bind.
module dxc_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic              cfg_byte,
    input logic              cfg_half,
    input logic [1:0]        cfg_mode,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_we,
    input logic              ram_re,
    input logic [1:0]        ram_be,
    input logic              periph_re,
    input logic              periph_we,
    input logic              irq,
    input logic              armed
);
    // R2: a RAM write always pairs with a peripheral read.
    assert_write_pairs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (periph_re && !ram_re && !periph_we));

    // R3: a RAM read always pairs with a peripheral write.
    assert_read_pairs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |-> (periph_we && !ram_we && !periph_re));

    // R4: byte elements touch exactly one lane.
    assert_byte_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ram_we || ram_re) && cfg_byte) |-> ($countones(ram_be) == 1));

    // R5: word elements use an even address and both lanes.
    assert_word_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ram_we || ram_re) && !cfg_byte) |-> (!ram_addr[0] && ram_be == 2'b11));

    // R9: an interrupt always follows a transfer cycle.
    assert_irq_after_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ram_we || ram_re));

    // R9: a full-block interrupt in one-shot mode comes with disarm.
    assert_oneshot_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cfg_mode == 2'd0 && !cfg_half) |-> !armed);

    // R13: a low enable leaves the channel disarmed on the next cycle.
    assert_disable_disarms_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !armed);

endmodule

bind dma_xfer_chan dxc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_byte  (cfg_byte),
    .cfg_half  (cfg_half),
    .cfg_mode  (cfg_mode),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_be    (ram_be),
    .periph_re (periph_re),
    .periph_we (periph_we),
    .irq       (irq),
    .armed     (armed)
);

// File: tb/dma_xfer_chan_test.sv
`timescale 1ns/100ps
module dma_xfer_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_dir = 1'b0, cfg_byte = 1'b0, cfg_incr = 1'b1;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_half = 1'b0;
    logic [4:0]  cfg_src_sel = 5'd2;
    logic [9:0]  cfg_count = '0;
    logic [11:0] cfg_start_a = '0, cfg_start_b = '0;
    logic [18:0] req_vec = '0;
    logic        sw_force = 1'b0;
    logic [11:0] ram_addr;
    logic        ram_we, ram_re, periph_re, periph_we, irq, armed, pp_last_alt;
    logic [1:0]  ram_be;
    logic [15:0] ram_wdata, ram_rdata, periph_wdata;
    logic [15:0] periph_rdata = '0;
    logic [15:0] mem [0:63];

    int tests = 0, fails = 0;
    bit finished = 0;

    logic        s_we, s_re, s_pre, s_pwe, a_irq, a_armed, a_alt;
    logic [11:0] s_addr;
    logic [1:0]  s_be;
    logic [15:0] s_rw, s_pw;

    localparam logic [18:0] SRC2 = 19'h4;
    // dir, byte, addr, data in, expected addr, expected be, expected data
    localparam logic [59:0] VEC [0:6] = '{
        {1'b0, 1'b0, 12'h010, 16'hBEEF, 12'h010, 2'b11, 16'hBEEF},
        {1'b0, 1'b1, 12'h021, 16'h00A5, 12'h021, 2'b10, 16'hA5A5},
        {1'b0, 1'b1, 12'h020, 16'h123C, 12'h020, 2'b01, 16'h3C3C},
        {1'b0, 1'b0, 12'h033, 16'h5555, 12'h032, 2'b11, 16'h5555},
        {1'b1, 1'b0, 12'h040, 16'hCAFE, 12'h040, 2'b11, 16'hCAFE},
        {1'b1, 1'b1, 12'h045, 16'h7E81, 12'h045, 2'b10, 16'h007E},
        {1'b1, 1'b1, 12'h046, 16'h9A3B, 12'h046, 2'b01, 16'h003B}
    };

    always #2.5 clk = ~clk;

    assign ram_rdata = mem[ram_addr[6:1]];

    // RAM model with byte lanes.
    always @(posedge clk) begin
        if (ram_we) begin
            if (ram_be[0]) mem[ram_addr[6:1]][7:0]  <= ram_wdata[7:0];
            if (ram_be[1]) mem[ram_addr[6:1]][15:8] <= ram_wdata[15:8];
        end
    end

    dma_xfer_chan uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dir(cfg_dir),
        .cfg_byte(cfg_byte), .cfg_incr(cfg_incr), .cfg_mode(cfg_mode),
        .cfg_half(cfg_half), .cfg_src_sel(cfg_src_sel), .cfg_count(cfg_count),
        .cfg_start_a(cfg_start_a), .cfg_start_b(cfg_start_b), .req_vec(req_vec),
        .sw_force(sw_force), .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
        .ram_be(ram_be), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .periph_re(periph_re), .periph_we(periph_we), .periph_wdata(periph_wdata),
        .periph_rdata(periph_rdata), .irq(irq), .armed(armed), .pp_last_alt(pp_last_alt)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Re-arm: enable low for one cycle, then high; returns with the channel armed.
    task automatic arm();
        cfg_en = 1'b0;
        @(negedge clk);
        cfg_en = 1'b1;
        @(negedge clk);
    endtask

    // Drive one request pattern, capture the strobe cycle and the cycle after.
    task automatic fire(input logic [18:0] m, input bit f);
        req_vec = m;
        sw_force = f;
        @(negedge clk);
        s_we = ram_we; s_re = ram_re; s_pre = periph_re; s_pwe = periph_we;
        s_addr = ram_addr; s_be = ram_be; s_rw = ram_wdata; s_pw = periph_wdata;
        req_vec = '0;
        sw_force = 1'b0;
        @(negedge clk);
        a_irq = irq; a_armed = armed; a_alt = pp_last_alt;
    endtask

    // Move n elements and check addresses and the interrupt position.
    task automatic run_block(input string tag, input logic [11:0] base,
                             input int stride, input int n, input int irq_at);
        for (int k = 0; k < n; k++) begin
            fire(SRC2, 1'b0);
            check(tag, {31'd0, s_we | s_re}, 32'd1);
            check(tag, {20'd0, s_addr}, {20'd0, base + 12'(k * stride)});
            check(tag, {31'd0, a_irq}, {31'd0, k == irq_at});
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 armed", {31'd0, armed}, 0);
        check("R1 alt", {31'd0, pp_last_alt}, 0);
        check("R1 strobes", {28'd0, ram_we, ram_re, periph_re, periph_we}, 0);

        // Vector table: single-element one-shot blocks.
        for (int i = 0; i < 7; i++) begin
            cfg_dir = VEC[i][59]; cfg_byte = VEC[i][58];
            cfg_start_a = VEC[i][57:46];
            cfg_mode = 2'd0; cfg_count = '0; cfg_incr = 1'b1; cfg_half = 1'b0;
            if (cfg_dir) mem[VEC[i][52:47]] = VEC[i][45:30];
            else periph_rdata = VEC[i][45:30];
            arm();
            fire(SRC2, 1'b0);
            if (!cfg_dir) begin
                check("R2 strobes", {30'd0, s_we, s_pre}, 32'd3);
                check(cfg_byte ? "R4 data" : "R5 data", {16'd0, s_rw}, {16'd0, VEC[i][15:0]});
            end else begin
                check("R3 strobes", {30'd0, s_re, s_pwe}, 32'd3);
                check(cfg_byte ? "R4 data" : "R5 data", {16'd0, s_pw}, {16'd0, VEC[i][15:0]});
            end
            check(cfg_byte ? "R4 addr" : "R5 addr", {20'd0, s_addr}, {20'd0, VEC[i][29:18]});
            check(cfg_byte ? "R4 be" : "R5 be", {30'd0, s_be}, {30'd0, VEC[i][17:16]});
            check("R9 irq", {31'd0, a_irq}, 1);
            check("R9 armed", {31'd0, a_armed}, 0);
        end
        cfg_dir = 1'b0;

        // R5 R9: word increment, one-shot, then ignored request.
        cfg_byte = 1'b0; cfg_count = 10'd3; cfg_start_a = 12'h100;
        arm();
        run_block("R5", 12'h100, 2, 4, 3);
        check("R9 disarmed", {31'd0, a_armed}, 0);
        fire(SRC2, 1'b0);
        check("R9 no xfer", {31'd0, s_we}, 0);

        // R4: byte increment.
        cfg_byte = 1'b1; cfg_count = 10'd2; cfg_start_a = 12'h201;
        arm();
        run_block("R4", 12'h201, 1, 3, 2);

        // R6: fixed address.
        cfg_byte = 1'b0; cfg_incr = 1'b0; cfg_start_a = 12'h300;
        arm();
        run_block("R6", 12'h300, 0, 3, 2);
        cfg_incr = 1'b1;

        // R7: source select.
        cfg_count = '0; cfg_src_sel = 5'd4;
        arm();
        fire(19'h8, 1'b0);
        check("R7 other line", {31'd0, s_we}, 0);
        fire(19'h10, 1'b0);
        check("R7 selected line", {31'd0, s_we}, 1);
        cfg_src_sel = 5'd25;
        arm();
        fire('1, 1'b0);
        check("R7 bad select", {31'd0, s_we}, 0);
        check("R7 still armed", {31'd0, a_armed}, 1);

        // R8: software force.
        arm();
        fire('0, 1'b1);
        check("R8 force", {31'd0, s_we}, 1);
        check("R8 irq", {31'd0, a_irq}, 1);
        cfg_src_sel = 5'd2;

        // R10: continuous.
        cfg_mode = 2'd1; cfg_count = 10'd1; cfg_start_a = 12'h080;
        arm();
        run_block("R10", 12'h080, 2, 2, 1);
        check("R10 armed", {31'd0, a_armed}, 1);
        run_block("R10", 12'h080, 2, 2, 1);

        // R11: ping-pong.
        cfg_mode = 2'd2; cfg_start_a = 12'h100; cfg_start_b = 12'h180;
        arm();
        run_block("R11", 12'h100, 2, 2, 1);
        check("R11 alt primary", {31'd0, a_alt}, 0);
        run_block("R11", 12'h180, 2, 2, 1);
        check("R11 alt secondary", {31'd0, a_alt}, 1);
        run_block("R11", 12'h100, 2, 2, 1);
        check("R11 alt back", {31'd0, a_alt}, 0);
        check("R11 armed", {31'd0, a_armed}, 1);
        cfg_mode = 2'd3;
        arm();
        run_block("R11", 12'h100, 2, 2, 1);
        check("R11 one pass armed", {31'd0, a_armed}, 1);
        run_block("R11", 12'h180, 2, 2, 1);
        check("R11 one pass stop", {31'd0, a_armed}, 0);
        check("R11 one pass alt", {31'd0, a_alt}, 1);

        // R12: half-block interrupt.
        cfg_mode = 2'd0; cfg_half = 1'b1; cfg_count = 10'd4; cfg_start_a = 12'h000;
        arm();
        run_block("R12", 12'h000, 2, 5, 1);
        check("R12 stop", {31'd0, a_armed}, 0);
        cfg_count = '0; cfg_start_a = 12'h010;
        arm();
        run_block("R12", 12'h010, 2, 1, -1);
        cfg_half = 1'b0;

        // R13: abort and restart.
        cfg_count = 10'd3; cfg_start_a = 12'h040;
        arm();
        run_block("R13", 12'h040, 2, 2, -1);
        cfg_en = 1'b0;
        @(negedge clk);
        check("R13 armed", {31'd0, armed}, 0);
        check("R13 irq", {31'd0, irq}, 0);
        fire(SRC2, 1'b0);
        check("R13 no xfer", {31'd0, s_we}, 0);
        arm();
        run_block("R13", 12'h040, 2, 4, 3);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule